// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block is the register-side front end of an SPI host controller. Software reaches it over a 32-bit bus that only performs whole-word accesses, addressed by word. The block holds the configuration words for the serial engine. It buffers outgoing bytes in a transmit queue and incoming bytes in a receive queue, and raises one interrupt line from two fill-level conditions.

Bytes written to the transmit data word go into the transmit queue. They leave it one at a time through a valid/ready handshake to a serial shift engine. For each byte it sends, the engine returns one byte with a completion pulse, and that byte may be stored in the receive queue. The empty and full conditions of the queues appear in bit 31 of the two data words, so no separate status register exists. Chip-select outputs follow the chip-select default and mode registers. They are updated only when a chip-select id or chip-select mode write is accepted.

Top module: `spi_host_regs`

## Requirements
- R1: After reset, the clock divider word (0x00) reads 3, delay word A (0x28) reads 0x1001, delay word B (0x2C) reads 1, chip-select default (0x14) has one bit set per chip select, every other register reads 0, all chip-select outputs are high, the interrupt is low and no transmit request is pending.
- R2: The clock mode (0x04), frame format (0x40), interrupt enable (0x70), clock divider (0x00) and both delay words store a full 32-bit write and read it back unchanged.
- R3: A read of the transmit data word (0x48) returns 0x80000000 while the transmit queue holds FIFO_DEPTH bytes, and 0 otherwise. A write there enqueues bits [7:0] unless the queue is full, in which case the write is dropped.
- R4: txValid is high while the transmit queue is non-empty, and txByte presents the oldest byte. A byte leaves the queue on a cycle with txValid and txReady both high, so bytes go out in write order.
- R5: On an rxDone pulse, rxByte enters the receive queue only when frame format bit 3 is 0 and the queue is not full. Otherwise the byte is discarded.
- R6: A read of the receive data word (0x4C) returns 0x80000000 when the receive queue is empty. Otherwise it returns the oldest byte in bits [7:0] with bit 31 clear, and removes that byte.
- R7: The pending word (0x74) has bit 0 set while the transmit count is strictly below the transmit level (0x50), and bit 1 set while the receive count is strictly above the receive level (0x54). Writes to 0x74 have no effect.
- R8: irq is high exactly when some bit of the pending word [1:0] is set and the same bit of the interrupt enable word is set.
- R9: A write of FIFO_DEPTH or more to either level register is discarded, and the register keeps its value.
- R10: Discarded writes: a chip-select id (0x10) not below NUM_CS, a chip-select mode (0x18) above 3, and a chip-select default (0x14) with any bit at position NUM_CS or higher.
- R11: On an accepted write to 0x10 or 0x18, each chip-select output whose default bit is set becomes 1 if the (new) mode is 0 and 0 otherwise. Outputs whose default bit is clear hold their value, and a write to 0x14 alone changes no output.
- R12: Writes to reserved offsets (0x08, 0x0C, 0x1C, 0x20, 0x24, 0x30 to 0x3C, 0x44, 0x58, 0x5C, 0x68, 0x6C), to 0x60, to 0x64 and to 0x4C change nothing, and those offsets other than 0x4C read 0. Byte offsets 0x78 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRe | input | 1 | Read strobe; read data is valid in the same cycle |
| busWe | input | 1 | Write strobe |
| busWordAddr | input | 10 | Word address (byte offset divided by 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request |
| txValid | output | 1 | Transmit byte available to the shift engine |
| txByte | output | 8 | Oldest transmit byte |
| txReady | input | 1 | Shift engine takes txByte |
| rxDone | input | 1 | Shift engine finished a byte |
| rxByte | input | 8 | Byte returned by the shift engine |
| csOut | output | NUM_CS | Chip-select lines |

## Verification
On every cycle, the assertions check that the queues never pass their depth, that a push into a full queue leaves the count unchanged, and that a receive pop only arrives while data is present. They also check that the direction bit blocks capture, that out-of-range level and mode writes leave the registers unchanged, and that chip-select lines only move on chip-select writes. Some properties need several steps to show, and only the bench scenarios cover them. These are byte ordering through both queues, the folded flag values, the exact pending and interrupt results for chosen levels, and the way the default mask selects which lines an accepted write updates.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int WORD_AW = 10;
  typedef logic [WORD_AW-1:0] wordAddr_t;

  localparam wordAddr_t OFS_CLKDIV  = wordAddr_t'(12'h000 >> 2);
  localparam wordAddr_t OFS_CLKMODE = wordAddr_t'(12'h004 >> 2);
  localparam wordAddr_t OFS_CSSEL   = wordAddr_t'(12'h010 >> 2);
  localparam wordAddr_t OFS_CSDFLT  = wordAddr_t'(12'h014 >> 2);
  localparam wordAddr_t OFS_CSMODE  = wordAddr_t'(12'h018 >> 2);
  localparam wordAddr_t OFS_DLYA    = wordAddr_t'(12'h028 >> 2);
  localparam wordAddr_t OFS_DLYB    = wordAddr_t'(12'h02C >> 2);
  localparam wordAddr_t OFS_FRAME   = wordAddr_t'(12'h040 >> 2);
  localparam wordAddr_t OFS_TXWIN   = wordAddr_t'(12'h048 >> 2);
  localparam wordAddr_t OFS_RXWIN   = wordAddr_t'(12'h04C >> 2);
  localparam wordAddr_t OFS_TXLVL   = wordAddr_t'(12'h050 >> 2);
  localparam wordAddr_t OFS_RXLVL   = wordAddr_t'(12'h054 >> 2);
  localparam wordAddr_t OFS_INTEN   = wordAddr_t'(12'h070 >> 2);
  localparam wordAddr_t OFS_INTPEND = wordAddr_t'(12'h074 >> 2);

  localparam logic [31:0] RST_CLKDIV = 32'h0000_0003;
  localparam logic [31:0] RST_DLYA   = 32'h0000_1001;
  localparam logic [31:0] RST_DLYB   = 32'h0000_0001;
  localparam logic [31:0] FLAG_TOP   = 32'h8000_0000;
  localparam int          FRAME_DIR_BIT = 3;

  typedef struct packed {
    logic       txPush;
    logic       rxPop;
    logic [7:0] pushByte;
  } strobe_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdata  = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= wdata;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/spi_host_dp.sv
module spi_host_dp import spi_host_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          dirNoRx,
  output logic          txValid,
  output logic [7:0]    txByte,
  input  logic          txReady,
  input  logic          rxDone,
  input  logic [7:0]    rxByte,
  output logic [CW-1:0] txCount,
  output logic          txFull,
  output logic [CW-1:0] rxCount,
  output logic          rxEmpty,
  output logic [7:0]    rxHead
);
  logic txEmpty, rxFull;

  spi_host_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk(clk), .rstN(rstN),
    .push(stb.txPush), .pop(txValid && txReady),
    .wdata(stb.pushByte), .rdata(txByte),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  assign txValid = !txEmpty;

  spi_host_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk(clk), .rstN(rstN),
    .push(rxDone && !dirNoRx), .pop(stb.rxPop),
    .wdata(rxByte), .rdata(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assert_dir_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && dirNoRx && !stb.rxPop) |=> (rxCount == $past(rxCount)));
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxFull && !stb.rxPop) |=> (rxCount == $past(rxCount)));
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxPop |-> !rxEmpty);
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl import spi_host_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int NUM_CS = 2,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(DEPTH),
  localparam int SW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRe,
  input  logic              busWe,
  input  wordAddr_t         busWordAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CW-1:0]     txCount,
  input  logic              txFull,
  input  logic [CW-1:0]     rxCount,
  input  logic              rxEmpty,
  input  logic [7:0]        rxHead,
  output strobe_t           stb,
  output logic              dirNoRx,
  output logic              irq,
  output logic [NUM_CS-1:0] csOut
);
  logic [31:0]       clkDiv, clkMode, dlyA, dlyB, frame, intEn;
  logic [SW-1:0]     csSel;
  logic [NUM_CS-1:0] csDflt;
  logic [1:0]        csMode;
  logic [LW-1:0]     txLvl, rxLvl;
  logic [1:0]        pend;

  logic wrSel, wrDflt, wrMode, lvlOk, csUpdate;
  logic [1:0] modeNext;

  assign lvlOk   = busWdata < 32'(DEPTH);
  assign wrSel   = busWe && busWordAddr == OFS_CSSEL  && busWdata < 32'(NUM_CS);
  assign wrDflt  = busWe && busWordAddr == OFS_CSDFLT && (busWdata >> NUM_CS) == 32'd0;
  assign wrMode  = busWe && busWordAddr == OFS_CSMODE && busWdata <= 32'd3;
  assign csUpdate = wrSel || wrMode;
  assign modeNext = wrMode ? busWdata[1:0] : csMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkDiv  <= RST_CLKDIV;
      clkMode <= '0;
      dlyA    <= RST_DLYA;
      dlyB    <= RST_DLYB;
      frame   <= '0;
      intEn   <= '0;
      csSel   <= '0;
      csDflt  <= '1;
      csMode  <= '0;
      txLvl   <= '0;
      rxLvl   <= '0;
    end else begin
      if (busWe) begin
        case (busWordAddr)
          OFS_CLKDIV:  clkDiv  <= busWdata;
          OFS_CLKMODE: clkMode <= busWdata;
          OFS_DLYA:    dlyA    <= busWdata;
          OFS_DLYB:    dlyB    <= busWdata;
          OFS_FRAME:   frame   <= busWdata;
          OFS_INTEN:   intEn   <= busWdata;
          OFS_TXLVL:   if (lvlOk) txLvl <= busWdata[LW-1:0];
          OFS_RXLVL:   if (lvlOk) rxLvl <= busWdata[LW-1:0];
          default: ;
        endcase
      end
      if (wrSel)  csSel  <= busWdata[SW-1:0];
      if (wrDflt) csDflt <= busWdata[NUM_CS-1:0];
      if (wrMode) csMode <= busWdata[1:0];
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csLine
    always_ff @(posedge clk) begin
      if (!rstN)                      csOut[i] <= 1'b1;
      else if (csUpdate && csDflt[i]) csOut[i] <= (modeNext == 2'd0);
    end
  end

  assign pend[0] = txCount < CW'(txLvl);
  assign pend[1] = rxCount > CW'(rxLvl);
  assign irq     = |(pend & intEn[1:0]);
  assign dirNoRx = frame[FRAME_DIR_BIT];

  always_comb begin
    stb          = '0;
    stb.pushByte = busWdata[7:0];
    stb.txPush   = busWe && busWordAddr == OFS_TXWIN && !txFull;
    stb.rxPop    = busRe && busWordAddr == OFS_RXWIN && !rxEmpty;
  end

  always_comb begin
    case (busWordAddr)
      OFS_CLKDIV:  busRdata = clkDiv;
      OFS_CLKMODE: busRdata = clkMode;
      OFS_CSSEL:   busRdata = 32'(csSel);
      OFS_CSDFLT:  busRdata = 32'(csDflt);
      OFS_CSMODE:  busRdata = 32'(csMode);
      OFS_DLYA:    busRdata = dlyA;
      OFS_DLYB:    busRdata = dlyB;
      OFS_FRAME:   busRdata = frame;
      OFS_TXWIN:   busRdata = txFull ? FLAG_TOP : 32'd0;
      OFS_RXWIN:   busRdata = rxEmpty ? FLAG_TOP : {24'd0, rxHead};
      OFS_TXLVL:   busRdata = 32'(txLvl);
      OFS_RXLVL:   busRdata = 32'(rxLvl);
      OFS_INTEN:   busRdata = intEn;
      OFS_INTPEND: busRdata = {30'd0, pend};
      default:     busRdata = 32'd0;
    endcase
  end

  assert_lvl_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busWordAddr == OFS_TXLVL && busWdata >= 32'(DEPTH)) |=> $stable(txLvl));
  assert_rxlvl_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busWordAddr == OFS_RXLVL && busWdata >= 32'(DEPTH)) |=> $stable(rxLvl));
  assert_mode_reject_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busWordAddr == OFS_CSMODE && busWdata > 32'd3) |=> $stable(csMode));
  assert_cs_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && (busWordAddr == OFS_CSSEL || busWordAddr == OFS_CSMODE)) |=> $stable(csOut));
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs import spi_host_pkg::*; #(
  parameter int FIFO_DEPTH = 8,
  parameter int NUM_CS     = 2,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busRe,
  input  logic               busWe,
  input  logic [WORD_AW-1:0] busWordAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  output logic               irq,
  output logic               txValid,
  output logic [7:0]         txByte,
  input  logic               txReady,
  input  logic               rxDone,
  input  logic [7:0]         rxByte,
  output logic [NUM_CS-1:0]  csOut
);
  strobe_t       stb;
  logic          dirNoRx, txFull, rxEmpty;
  logic [CW-1:0] txCount, rxCount;
  logic [7:0]    rxHead;

  spi_host_ctrl #(.DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busRe(busRe), .busWe(busWe), .busWordAddr(busWordAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .txCount(txCount), .txFull(txFull), .rxCount(rxCount),
    .rxEmpty(rxEmpty), .rxHead(rxHead),
    .stb(stb), .dirNoRx(dirNoRx), .irq(irq), .csOut(csOut)
  );

  spi_host_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dirNoRx(dirNoRx),
    .txValid(txValid), .txByte(txByte), .txReady(txReady),
    .rxDone(rxDone), .rxByte(rxByte),
    .txCount(txCount), .txFull(txFull), .rxCount(rxCount),
    .rxEmpty(rxEmpty), .rxHead(rxHead)
  );
endmodule

// File: tb/spi_host_regs_bench.sv
module spi_host_regs_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic busRe = 0, busWe = 0, txReady = 0, rxDone = 0;
  logic [9:0] busWordAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [7:0] txByte, rxByte = '0;
  logic irq, txValid;
  logic [1:0] csOut;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_host_regs u_spi_host_regs (
    .clk(clk), .rstN(rstN), .busRe(busRe), .busWe(busWe),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .txValid(txValid), .txByte(txByte), .txReady(txReady),
    .rxDone(rxDone), .rxByte(rxByte), .csOut(csOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    busWe = 1; busWordAddr = ofs[11:2]; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic rd(input logic [11:0] ofs, output logic [31:0] d);
    @(negedge clk);
    busRe = 1; busWordAddr = ofs[11:2];
    #2 d = busRdata;
    @(posedge clk);
    @(negedge clk);
    busRe = 0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] ofs, input logic [31:0] exp);
    logic [31:0] d;
    rd(ofs, d);
    chk(req, d, exp);
  endtask

  task automatic shiftOne(input string req, input logic [7:0] ret, input logic [7:0] expTx);
    @(negedge clk);
    chk(req, {31'd0, txValid}, 32'd1);
    chk(req, {24'd0, txByte}, {24'd0, expTx});
    txReady = 1;
    @(posedge clk);
    @(negedge clk);
    txReady = 0; rxDone = 1; rxByte = ret;
    @(posedge clk);
    @(negedge clk);
    rxDone = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 txValid", {31'd0, txValid}, 0);
    chk("R1 csOut", {30'd0, csOut}, 32'h3);
    rdChk("R1 clkdiv", 12'h000, 32'h3);
    rdChk("R1 dlyA", 12'h028, 32'h1001);
    rdChk("R1 dlyB", 12'h02C, 32'h1);
    rdChk("R1 csdflt", 12'h014, 32'h3);
    rdChk("R1 csmode", 12'h018, 0);
    rdChk("R1 pend", 12'h074, 0);
    rdChk("R1 txlvl", 12'h050, 0);
    rdChk("R3 tx not full", 12'h048, 0);
    rdChk("R6 rx empty", 12'h04C, 32'h8000_0000);
  endtask

  task automatic t_plainRegs;
    wr(12'h004, 32'hA5A5_0001); rdChk("R2 clkmode", 12'h004, 32'hA5A5_0001);
    wr(12'h040, 32'h1234_5670); rdChk("R2 frame", 12'h040, 32'h1234_5670);
    wr(12'h070, 32'hFFFF_FFFC); rdChk("R2 inten", 12'h070, 32'hFFFF_FFFC);
    wr(12'h000, 32'h0000_0010); rdChk("R2 clkdiv", 12'h000, 32'h10);
    wr(12'h040, 0); wr(12'h070, 0);
  endtask

  task automatic t_fifoFlow;
    for (int i = 0; i < 9; i++) wr(12'h048, 32'hFFFF_FF10 + i);
    rdChk("R3 tx full flag", 12'h048, 32'h8000_0000);
    for (int i = 0; i < 8; i++) shiftOne("R4 order", 8'h80 + 8'(i), 8'h10 + 8'(i));
    @(negedge clk);
    chk("R3 ninth byte dropped", {31'd0, txValid}, 0);
    rdChk("R3 tx not full after drain", 12'h048, 0);
    @(negedge clk); rxDone = 1; rxByte = 8'hEE;
    @(negedge clk); rxDone = 0;
    for (int i = 0; i < 8; i++) rdChk("R6 rx byte", 12'h04C, 32'h80 + i);
    rdChk("R5 full drop", 12'h04C, 32'h8000_0000);
  endtask

  task automatic t_dir;
    wr(12'h040, 32'h8);
    wr(12'h048, 32'h55);
    shiftOne("R5 dir tx", 8'h66, 8'h55);
    rdChk("R5 dir set no capture", 12'h04C, 32'h8000_0000);
    wr(12'h040, 0);
    wr(12'h048, 32'h57);
    shiftOne("R5 dir clear tx", 8'h67, 8'h57);
    rdChk("R5 dir clear captured", 12'h04C, 32'h67);
  endtask

  task automatic t_wm;
    wr(12'h050, 3);
    rdChk("R7 txwm pend", 12'h074, 1);
    chk("R8 irq masked", {31'd0, irq}, 0);
    wr(12'h070, 1);
    chk("R8 irq txwm", {31'd0, irq}, 1);
    wr(12'h074, 0);
    rdChk("R7 pend write ignored", 12'h074, 1);
    wr(12'h050, 8);
    rdChk("R9 txlvl reject", 12'h050, 3);
    wr(12'h050, 0);
    rdChk("R7 txwm clear", 12'h074, 0);
    chk("R8 irq low", {31'd0, irq}, 0);
    wr(12'h048, 32'h21);
    shiftOne("R7 tx", 8'h31, 8'h21);
    rdChk("R7 rxwm pend", 12'h074, 2);
    wr(12'h070, 2);
    chk("R8 irq rxwm", {31'd0, irq}, 1);
    wr(12'h054, 1);
    rdChk("R7 rxwm equal", 12'h074, 0);
    chk("R8 irq drop", {31'd0, irq}, 0);
    wr(12'h054, 9);
    rdChk("R9 rxlvl reject", 12'h054, 1);
    rdChk("R6 pop", 12'h04C, 32'h31);
    wr(12'h054, 0); wr(12'h070, 0);
  endtask

  task automatic t_cs;
    wr(12'h014, 32'h4);
    rdChk("R10 csdflt reject", 12'h014, 3);
    wr(12'h018, 5);
    rdChk("R10 csmode reject", 12'h018, 0);
    wr(12'h014, 1);
    rdChk("R10 csdflt accept", 12'h014, 1);
    chk("R11 dflt write no update", {30'd0, csOut}, 3);
    wr(12'h018, 2);
    chk("R11 masked update", {30'd0, csOut}, 2);
    wr(12'h010, 2);
    rdChk("R10 cssel reject", 12'h010, 0);
    wr(12'h010, 1);
    rdChk("R10 cssel accept", 12'h010, 1);
    chk("R11 sel keeps", {30'd0, csOut}, 2);
    wr(12'h014, 3);
    wr(12'h010, 0);
    chk("R11 both low", {30'd0, csOut}, 0);
    wr(12'h018, 0);
    chk("R11 both high", {30'd0, csOut}, 3);
  endtask

  task automatic t_reserved;
    wr(12'h008, 32'hFFFF); rdChk("R12 reserved", 12'h008, 0);
    wr(12'h05C, 32'h7);    rdChk("R12 reserved 5c", 12'h05C, 0);
    wr(12'h060, 32'h1);    rdChk("R12 flash ctl", 12'h060, 0);
    wr(12'h064, 32'h1);    rdChk("R12 flash fmt", 12'h064, 0);
    wr(12'h04C, 32'h99);   rdChk("R12 rx write", 12'h04C, 32'h8000_0000);
    wr(12'h080, 32'h1);    rdChk("R12 past end", 12'h080, 0);
    rdChk("R12 no alias", 12'h000, 32'h10);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset;
    t_plainRegs;
    t_fifoFlow;
    t_dir;
    t_wm;
    t_cs;
    t_reserved;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule